// File: doc/BRIEF.md
# Interrupt flag/enable register file for a versatile interface peripheral

This block is the byte-wide register front end of a versatile-interface-style peripheral. A 4-bit register index taken from address bits 12:9 selects one of sixteen byte registers: two port data registers, two direction registers, a no-handshake port register, a shift register, an auxiliary control and a peripheral control register, six read-only views of external timer counter and latch values, and the interrupt flag and interrupt enable registers.

Timer counting and the shift handshake live in neighbouring blocks. They report events as one-cycle flag-set pulses. This block holds the flags, combines them with the enables into one level-sensitive interrupt output, and clears flags on the reads that consume an event. Only byte accesses act. Word and long accesses write nothing, return zero and have no read side-effect.

Top module: `via_irq_regfile`

## Requirements
- R1: After reset the enable register reads 0x44, the flag register reads 0x00, every held data register reads 0x00 and irq_o is low.
- R2: The register index is addr_i[12:9], and the other address bits are ignored. Indices 0, 1, 2, 3, 10, 11, 12 and 15 are separate read/write byte registers. Index 15 is the no-handshake port register and is distinct from index 1.
- R3: irq_o is high exactly when (flag AND enable AND 0x44) is nonzero. It follows a register update in the same cycle.
- R4: A byte write to the enable register (index 14) with bit 7 = 1 ORs in data bits 6:0. With bit 7 = 0 it clears each enable bit written as one. Enable bit 7 always reads 0.
- R5: A byte write to the flag register (index 13) clears every flag bit written as one and leaves the other bits unchanged.
- R6: A byte read of index 10 clears the shift flag (bit 2). A byte read of index 4 or 5 clears the timer-1 flag (bit 6). Reading the flag register itself clears nothing.
- R7: A pulse on sr_set_i sets flag bit 2 and a pulse on t1_set_i sets flag bit 6. A set pulse wins over a clear by write or by read in the same cycle.
- R8: size_i selects the access width: 0 is byte, 1 is word, 2 is long. A word or long write changes no register. A word or long read returns 0x00 and clears no flag.
- R9: Indices 4/5 read t1_cnt_i low/high, 6/7 read t1_latch_i low/high, and 8/9 read t2_cnt_i low/high. Writes to indices 4 to 9 change no register held here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 | Byte address; bits 12:9 are the register index |
| size_i | input | 2 | Access width: 0 byte, 1 word, 2 long |
| wr_en_i | input | 1 | Qualified write strobe |
| rd_en_i | input | 1 | Qualified read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| sr_set_i | input | 1 | Shift event pulse, sets flag bit 2 |
| t1_set_i | input | 1 | Timer-1 event pulse, sets flag bit 6 |
| t1_cnt_i | input | 16 | Timer-1 counter value |
| t1_latch_i | input | 16 | Timer-1 latch value |
| t2_cnt_i | input | 16 | Timer-2 counter value |
| port_b_o | output | 8 | Port B data register |
| port_a_o | output | 8 | Port A data register |
| dir_b_o | output | 8 | Port B direction register |
| dir_a_o | output | 8 | Port A direction register |
| shift_o | output | 8 | Shift register |
| aux_ctl_o | output | 8 | Auxiliary control register |
| per_ctl_o | output | 8 | Peripheral control register |
| port_a_nh_o | output | 8 | No-handshake port A register |
| irq_o | output | 1 | Level interrupt request |

## Verification
Each effect is due one rising edge after its stimulus. A strobe or pulse that is sampled at an edge updates the registers at that edge, and irq_o follows from those registers without a further delay. The registered rdata_o carries the read value at that same edge, from the state before any read clear. The bench drives every input on a falling edge, holds it across exactly one rising edge and samples the outputs on the next falling edge. Because of this, a read clear is seen only in a later read, and the priority cases put a set pulse and a clear into the same sampled edge.

// File: rtl/via_pkg.sv
package via_pkg;
  typedef enum logic [3:0] {
    IDX_PB      = 4'd0,
    IDX_PA      = 4'd1,
    IDX_DIRB    = 4'd2,
    IDX_DIRA    = 4'd3,
    IDX_T1C_LO  = 4'd4,
    IDX_T1C_HI  = 4'd5,
    IDX_T1L_LO  = 4'd6,
    IDX_T1L_HI  = 4'd7,
    IDX_T2C_LO  = 4'd8,
    IDX_T2C_HI  = 4'd9,
    IDX_SHIFT   = 4'd10,
    IDX_AUX     = 4'd11,
    IDX_PER     = 4'd12,
    IDX_FLAG    = 4'd13,
    IDX_ENA     = 4'd14,
    IDX_PA_NH   = 4'd15
  } reg_idx_e;

  localparam int unsigned IDX_W   = 4;
  localparam int unsigned N_REGS  = 1 << IDX_W;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FLAG_SR = 2;
  localparam int unsigned FLAG_T1 = 6;

  localparam logic [1:0] SIZE_BYTE = 2'd0;

  // indices backed by local storage
  function automatic logic is_held(input int unsigned idx);
    case (idx)
      0, 1, 2, 3, 10, 11, 12, 15: is_held = 1'b1;
      default:                    is_held = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/via_reg_decode.sv
module via_reg_decode
  import via_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned IDX_LSB = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output reg_idx_e          idx_o,
  output logic              byte_wr_o,
  output logic              byte_rd_o,
  output logic              wide_rd_o,
  output logic [N_REGS-1:0] wr_sel_o
);
  logic is_byte;

  assign is_byte   = (size_i == SIZE_BYTE);
  assign idx_o     = reg_idx_e'(addr_i[IDX_LSB +: IDX_W]);
  assign byte_wr_o = wr_en_i && is_byte;
  assign byte_rd_o = rd_en_i && is_byte;
  assign wide_rd_o = rd_en_i && !is_byte;

  always_comb begin
    wr_sel_o = '0;
    if (byte_wr_o) wr_sel_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/via_bit_cell.sv
module via_bit_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority so a same-cycle event is never dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/via_irq_ctrl.sv
module via_irq_ctrl
  import via_pkg::*;
#(
  parameter logic [DATA_W-1:0] IRQ_MASK = 8'h44,
  parameter logic [DATA_W-1:0] EN_RST   = 8'h44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_vec_i,
  input  logic [DATA_W-1:0] rd_clr_vec_i,
  input  logic              flag_wr_i,
  input  logic              ena_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] flag_q_o,
  output logic [DATA_W-1:0] en_q_o,
  output logic              irq_o
);
  localparam int unsigned CTL = DATA_W - 1;

  logic ena_set_mode;
  assign ena_set_mode = wdata_i[CTL];

  for (genvar i = 0; i < DATA_W; i++) begin : g_flag
    via_bit_cell #(.RST_VAL(1'b0)) u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_vec_i[i]),
      .clr_i ((flag_wr_i && wdata_i[i]) || rd_clr_vec_i[i]),
      .q_o   (flag_q_o[i])
    );
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_en
    if (i == CTL) begin : g_ctl
      assign en_q_o[i] = 1'b0;
    end else begin : g_bit
      via_bit_cell #(.RST_VAL(EN_RST[i])) u_en (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (ena_wr_i && ena_set_mode && wdata_i[i]),
        .clr_i (ena_wr_i && !ena_set_mode && wdata_i[i]),
        .q_o   (en_q_o[i])
      );
    end
  end

  assign irq_o = |(flag_q_o & en_q_o & IRQ_MASK);
endmodule

// File: rtl/via_data_regs.sv
module via_data_regs
  import via_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REGS-1:0] wr_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] regs_o [N_REGS]
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    if (is_held(i)) begin : g_held
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= '0;
        else if (wr_sel_i[i]) q <= wdata_i;
      end
      assign regs_o[i] = q;
    end else begin : g_none
      assign regs_o[i] = '0;
    end
  end
endmodule

// File: rtl/via_irq_regfile.sv
module via_irq_regfile
  import via_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 13,
  parameter int unsigned       IDX_LSB  = 9,
  parameter logic [DATA_W-1:0] IRQ_MASK = 8'h44,
  parameter logic [DATA_W-1:0] EN_RST   = 8'h44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sr_set_i,
  input  logic              t1_set_i,
  input  logic [15:0]       t1_cnt_i,
  input  logic [15:0]       t1_latch_i,
  input  logic [15:0]       t2_cnt_i,
  output logic [DATA_W-1:0] port_b_o,
  output logic [DATA_W-1:0] port_a_o,
  output logic [DATA_W-1:0] dir_b_o,
  output logic [DATA_W-1:0] dir_a_o,
  output logic [DATA_W-1:0] shift_o,
  output logic [DATA_W-1:0] aux_ctl_o,
  output logic [DATA_W-1:0] per_ctl_o,
  output logic [DATA_W-1:0] port_a_nh_o,
  output logic              irq_o
);
  reg_idx_e          idx;
  logic              byte_wr, byte_rd, wide_rd;
  logic [N_REGS-1:0] wr_sel;
  logic [DATA_W-1:0] regs [N_REGS];
  logic [DATA_W-1:0] flag_q, en_q;
  logic [DATA_W-1:0] set_vec, rd_clr_vec;
  logic [DATA_W-1:0] rd_mux;

  via_reg_decode #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_dec (
    .addr_i   (addr_i),
    .size_i   (size_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .idx_o    (idx),
    .byte_wr_o(byte_wr),
    .byte_rd_o(byte_rd),
    .wide_rd_o(wide_rd),
    .wr_sel_o (wr_sel)
  );

  via_data_regs u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_sel_i(wr_sel),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[FLAG_SR]    = sr_set_i;
    set_vec[FLAG_T1]    = t1_set_i;
    rd_clr_vec          = '0;
    rd_clr_vec[FLAG_SR] = byte_rd && (idx == IDX_SHIFT);
    rd_clr_vec[FLAG_T1] = byte_rd && (idx == IDX_T1C_LO || idx == IDX_T1C_HI);
  end

  via_irq_ctrl #(.IRQ_MASK(IRQ_MASK), .EN_RST(EN_RST)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_vec_i   (set_vec),
    .rd_clr_vec_i(rd_clr_vec),
    .flag_wr_i   (wr_sel[IDX_FLAG]),
    .ena_wr_i    (wr_sel[IDX_ENA]),
    .wdata_i     (wdata_i),
    .flag_q_o    (flag_q),
    .en_q_o      (en_q),
    .irq_o       (irq_o)
  );

  always_comb begin
    case (idx)
      IDX_T1C_LO: rd_mux = t1_cnt_i[7:0];
      IDX_T1C_HI: rd_mux = t1_cnt_i[15:8];
      IDX_T1L_LO: rd_mux = t1_latch_i[7:0];
      IDX_T1L_HI: rd_mux = t1_latch_i[15:8];
      IDX_T2C_LO: rd_mux = t2_cnt_i[7:0];
      IDX_T2C_HI: rd_mux = t2_cnt_i[15:8];
      IDX_FLAG:   rd_mux = flag_q;
      IDX_ENA:    rd_mux = en_q;
      default:    rd_mux = regs[idx];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (byte_rd)  rdata_o <= rd_mux;
    else if (wide_rd)  rdata_o <= '0;
  end

  assign port_b_o    = regs[IDX_PB];
  assign port_a_o    = regs[IDX_PA];
  assign dir_b_o     = regs[IDX_DIRB];
  assign dir_a_o     = regs[IDX_DIRA];
  assign shift_o     = regs[IDX_SHIFT];
  assign aux_ctl_o   = regs[IDX_AUX];
  assign per_ctl_o   = regs[IDX_PER];
  assign port_a_nh_o = regs[IDX_PA_NH];
endmodule

// File: rtl/via_irq_regfile_chk.sv
module via_irq_regfile_chk #(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned IDX_LSB = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        wdata_i,
  input logic              sr_set_i,
  input logic              t1_set_i,
  input logic [7:0]        flag_q,
  input logic [7:0]        en_q,
  input logic              irq_o
);
  logic [3:0] idx;
  logic       is_byte;
  assign idx     = addr_i[IDX_LSB +: 4];
  assign is_byte = (size_i == 2'd0);

  assert_t1_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1_set_i && en_q[6] && !(wr_en_i && idx == 4'd14)) |=> irq_o);

  assert_ena_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_byte && idx == 4'd14 && wdata_i[7]) |=>
      ((en_q[6:0] & $past(wdata_i[6:0])) == $past(wdata_i[6:0])));

  assert_flag_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_byte && idx == 4'd13 && !sr_set_i && !t1_set_i) |=>
      ((flag_q & $past(wdata_i)) == 8'h00));

  assert_shift_rd_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && is_byte && idx == 4'd10 && !sr_set_i) |=> !flag_q[2]);

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_set_i |=> flag_q[2]);

  assert_wide_no_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !is_byte) |=> $stable(en_q));

  assert_ena_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[7]);
endmodule

bind via_irq_regfile via_irq_regfile_chk #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .size_i  (size_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .wdata_i (wdata_i),
  .sr_set_i(sr_set_i),
  .t1_set_i(t1_set_i),
  .flag_q  (flag_q),
  .en_q    (en_q),
  .irq_o   (irq_o)
);

// File: tb/via_irq_regfile_tb_top.sv
`timescale 1ns/1ps
module via_irq_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [1:0]  size = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        sr_set = 1'b0, t1_set = 1'b0;
  logic [7:0]  pb, pa, db, da, sh, ac, pc, pnh;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  via_irq_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .sr_set_i(sr_set), .t1_set_i(t1_set),
    .t1_cnt_i(16'h1234), .t1_latch_i(16'h5678), .t2_cnt_i(16'h9ABC),
    .port_b_o(pb), .port_a_o(pa), .dir_b_o(db), .dir_a_o(da),
    .shift_o(sh), .aux_ctl_o(ac), .per_ctl_o(pc), .port_a_nh_o(pnh),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one access held across a single rising edge; returns on the next falling edge
  task automatic bus(input logic wr, input logic rd, input logic [3:0] idx,
                     input logic [7:0] d, input logic [1:0] sz,
                     input logic srp, input logic t1p,
                     input logic [8:0] low = 9'h000);
    @(negedge clk);
    addr = {idx, low}; wdata = d; size = sz;
    wr_en = wr; rd_en = rd; sr_set = srp; t1_set = t1p;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; sr_set = 1'b0; t1_set = 1'b0; size = 2'd0;
  endtask

  task automatic wr8(input logic [3:0] idx, input logic [7:0] d);
    bus(1'b1, 1'b0, idx, d, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic rd8(input logic [3:0] idx);
    bus(1'b0, 1'b1, idx, 8'h00, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic pulse(input logic srp, input logic t1p);
    bus(1'b0, 1'b0, 4'd0, 8'h00, 2'd0, srp, t1p);
  endtask

  // {op, idx, data, expected}; op 0 = write, 1 = read and compare
  localparam int NV = 32;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd0,  8'h11, 8'h00}, {1'b1, 4'd0,  8'h00, 8'h11},  // R2
    {1'b0, 4'd1,  8'h22, 8'h00}, {1'b1, 4'd1,  8'h00, 8'h22},
    {1'b0, 4'd2,  8'h33, 8'h00}, {1'b1, 4'd2,  8'h00, 8'h33},
    {1'b0, 4'd3,  8'h44, 8'h00}, {1'b1, 4'd3,  8'h00, 8'h44},
    {1'b0, 4'd10, 8'h5A, 8'h00}, {1'b1, 4'd10, 8'h00, 8'h5A},
    {1'b0, 4'd11, 8'h6B, 8'h00}, {1'b1, 4'd11, 8'h00, 8'h6B},
    {1'b0, 4'd12, 8'h7C, 8'h00}, {1'b1, 4'd12, 8'h00, 8'h7C},
    {1'b0, 4'd15, 8'h8D, 8'h00}, {1'b1, 4'd15, 8'h00, 8'h8D},
    {1'b1, 4'd1,  8'h00, 8'h22},                               // R2 idx 15 apart from 1
    {1'b1, 4'd4,  8'h00, 8'h34}, {1'b1, 4'd5,  8'h00, 8'h12},  // R9
    {1'b1, 4'd6,  8'h00, 8'h78}, {1'b1, 4'd7,  8'h00, 8'h56},
    {1'b1, 4'd8,  8'h00, 8'hBC}, {1'b1, 4'd9,  8'h00, 8'h9A},
    {1'b0, 4'd5,  8'hFF, 8'h00}, {1'b1, 4'd5,  8'h00, 8'h12},
    {1'b0, 4'd14, 8'h01, 8'h00}, {1'b1, 4'd14, 8'h00, 8'h44},  // R4
    {1'b0, 4'd14, 8'h83, 8'h00}, {1'b1, 4'd14, 8'h00, 8'h47},
    {1'b0, 4'd14, 8'h04, 8'h00}, {1'b1, 4'd14, 8'h00, 8'h43},
    {1'b0, 4'd14, 8'hC4, 8'h00}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 port_b", pb, 8'h00);
    chk("R1 shift", sh, 8'h00);
    chk("R1 nh port", pnh, 8'h00);
    rd8(4'd14); chk("R1 enable", rdata, 8'h44);
    rd8(4'd13); chk("R1 flags", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        rd8(VEC[i][19:16]);
        chk($sformatf("table R2 R4 R9 step %0d", i), rdata, VEC[i][7:0]);
      end else begin
        wr8(VEC[i][19:16], VEC[i][15:8]);
      end
    end
    chk("R2 port_a pin", pa, 8'h22);
    chk("R2 aux pin", ac, 8'h6B);
    rd8(4'd14); chk("R4 enable after set", rdata, 8'h47);

    // R2 address bits outside 12:9 ignored
    bus(1'b1, 1'b0, 4'd12, 8'hE1, 2'd0, 1'b0, 1'b0, 9'h1FF);
    rd8(4'd12); chk("R2 low bits ignored", rdata, 8'hE1);

    // R7 / R3: timer-1 event raises irq
    pulse(1'b0, 1'b1);
    chk("R3 irq on t1", {7'd0, irq}, 8'h01);
    rd8(4'd13); chk("R7 t1 flag", rdata, 8'h40);
    rd8(4'd13); chk("R6 flag read no clear", rdata, 8'h40);

    // R5 write-one-to-clear
    wr8(4'd13, 8'h04);
    rd8(4'd13); chk("R5 other bit kept", rdata, 8'h40);
    wr8(4'd13, 8'h40);
    chk("R3 irq low after clear", {7'd0, irq}, 8'h00);
    rd8(4'd13); chk("R5 cleared", rdata, 8'h00);

    // R6 read side-effects
    pulse(1'b1, 1'b0);
    chk("R3 irq on shift", {7'd0, irq}, 8'h01);
    rd8(4'd10); chk("R6 shift data", rdata, 8'h5A);
    chk("R6 irq after shift read", {7'd0, irq}, 8'h00);
    rd8(4'd13); chk("R6 shift flag cleared", rdata, 8'h00);
    pulse(1'b0, 1'b1);
    rd8(4'd5);
    rd8(4'd13); chk("R6 idx5 clears t1", rdata, 8'h00);
    pulse(1'b0, 1'b1);
    rd8(4'd4);
    rd8(4'd13); chk("R6 idx4 clears t1", rdata, 8'h00);
    pulse(1'b0, 1'b1);
    rd8(4'd6);
    rd8(4'd13); chk("R6 latch read keeps t1", rdata, 8'h40);
    wr8(4'd13, 8'hFF);

    // R7 set wins over same-cycle clear
    bus(1'b1, 1'b0, 4'd13, 8'h40, 2'd0, 1'b0, 1'b1);
    rd8(4'd13); chk("R7 set beats write clear", rdata, 8'h40);
    bus(1'b0, 1'b1, 4'd10, 8'h00, 2'd0, 1'b1, 1'b0);
    rd8(4'd13); chk("R7 set beats read clear", rdata, 8'h44);

    // R3 mask by enable
    wr8(4'd14, 8'h44);
    chk("R3 irq masked", {7'd0, irq}, 8'h00);
    wr8(4'd14, 8'hC0);
    chk("R3 irq unmasked", {7'd0, irq}, 8'h01);
    wr8(4'd14, 8'h40);
    wr8(4'd14, 8'h83);
    chk("R3 non-irq enables only", {7'd0, irq}, 8'h00);
    wr8(4'd14, 8'hC4);

    // R8 wide accesses
    bus(1'b1, 1'b0, 4'd0, 8'hFF, 2'd1, 1'b0, 1'b0);
    rd8(4'd0); chk("R8 word write ignored", rdata, 8'h11);
    bus(1'b1, 1'b0, 4'd13, 8'hFF, 2'd2, 1'b0, 1'b0);
    rd8(4'd13); chk("R8 long write no clear", rdata, 8'h44);
    bus(1'b1, 1'b0, 4'd14, 8'h7F, 2'd1, 1'b0, 1'b0);
    rd8(4'd14); chk("R8 word write enable ignored", rdata, 8'h47);
    bus(1'b0, 1'b1, 4'd0, 8'h00, 2'd1, 1'b0, 1'b0);
    chk("R8 word read zero", rdata, 8'h00);
    bus(1'b0, 1'b1, 4'd10, 8'h00, 2'd2, 1'b0, 1'b0);
    chk("R8 long read zero", rdata, 8'h00);
    rd8(4'd13); chk("R8 wide read no clear", rdata, 8'h44);

    // R9 timer writes leave held registers alone
    wr8(4'd8, 8'hAA);
    rd8(4'd8); chk("R9 t2 low external", rdata, 8'hBC);
    rd8(4'd0); chk("R9 neighbour kept", rdata, 8'h11);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule